// File: doc/BRIEF.md
# Parity-Based Line Change Wake-Up Detector

The detector watches a group of asynchronous input lines and pulls an active-low wake request when one of them changes level. It keeps no per-line copy of the previous input. Each line first passes through a synchroniser. A parity tree then combines the synchronised lines with one balance bit. The block keeps the balance bit so that the total count of ones over all these bits is odd. While that holds, the wake output rests high. A change on a single line breaks the parity, and the registered output falls.

The processor services the request by pulsing a one-cycle re-arm strobe. On that strobe the block sets the balance bit to the value that makes the current combination odd again. This returns the output high, ready for the next change. The same balancing runs on its own for a short settle window after reset, so the block starts idle whatever levels the lines hold at that point. The wake output follows parity and is not latched. If the changed line goes back to its old level before the processor responds, the output returns high without a re-arm.

Top module: `parity_wake`

## Requirements
- R1: While reset is asserted, and for the first three clock edges after reset is released, `wakeN` is high whatever levels `lineIn` holds.
- R2: After the settle window, `wakeN` stays high for as long as `lineIn` does not change.
- R3: When exactly one line changes level, `wakeN` goes low on the third rising edge after the change, counting two synchroniser edges and one output register edge. It is still high after the second edge.
- R4: A one-cycle `rearmStrobe` that is high at a rising edge sets `wakeN` high on that edge. `wakeN` then stays high while `lineIn` is steady.
- R5: A level change on any one of the eight lines, from bit 0 to bit 7, is detected as in R3.
- R6: When two lines change level in the same cycle, the parity does not change and `wakeN` stays high. This is a known limit of the block.
- R7: If a changed line returns to its previous level with no re-arm, `wakeN` returns high three rising edges after that return.
- R8: A single-line pulse that covers exactly one rising edge drives `wakeN` low for exactly one cycle.
- R9: The check uses odd parity. `wakeN` is high exactly when the count of ones over the eight synchronised lines and the balance bit is odd. Re-arm and settle set the balance bit so that this count is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 8 | Monitored lines, asynchronous to clk |
| rearmStrobe | input | 1 | One-cycle processor re-arm pulse, synchronous to clk |
| wakeN | output | 1 | Registered active-low wake request |

## Verification
A line change reaches `wakeN` after three rising edges: two synchroniser flops and the output register. A re-arm strobe acts on the edge that samples it. The bench drives every stimulus on a falling edge. It then samples `wakeN` on later falling edges. For a change it checks after two edges, where the output must still be high, and after three, where it must be low. For a re-arm it checks one edge after the strobe. For the blind spot and for steady periods it checks over several cycles. The bound checker rebuilds the same three-edge delay from its own record of past `lineIn` values. Each fall or rise of `wakeN` must match a change in that record or a re-arm.

// File: rtl/pwake_pkg.sv
package pwake_pkg;
  typedef struct packed {
    logic loadBalance;
    logic forceIdle;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwake_datapath.sv
module pwake_datapath
  import pwake_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit ODD_PARITY  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  ctrlStrobe_t          strobes,
  output logic                 parityOk
);
  localparam int NUM_BITS = NUM_LINES + 1;
  localparam int LEAVES   = 1 << $clog2(NUM_BITS);
  localparam int NODES    = 2 * LEAVES - 1;

  logic [NUM_LINES-1:0] syncLines;
  logic                 balanceBit;
  logic [NODES-1:0]     treeNode;

  // per-line synchroniser chains
  for (genvar g = 0; g < NUM_LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] stageQ;
    always_ff @(posedge clk) begin
      if (!rstN) stageQ <= '0;
      else       stageQ <= {stageQ[SYNC_STAGES-2:0], lineIn[g]};
    end
    assign syncLines[g] = stageQ[SYNC_STAGES-1];
  end

  // leaves of the parity tree: lines, balance bit, zero padding
  for (genvar l = 0; l < LEAVES; l++) begin : gLeaf
    if (l < NUM_LINES) begin : gLine
      assign treeNode[LEAVES-1+l] = syncLines[l];
    end else if (l == NUM_LINES) begin : gBal
      assign treeNode[LEAVES-1+l] = balanceBit;
    end else begin : gPad
      assign treeNode[LEAVES-1+l] = 1'b0;
    end
  end

  // inner XOR nodes, balanced tree
  for (genvar n = 0; n < LEAVES - 1; n++) begin : gNode
    assign treeNode[n] = treeNode[2*n+1] ^ treeNode[2*n+2];
  end

  assign parityOk = (treeNode[0] == ODD_PARITY);

  // balance: flip when the current combination is off
  always_ff @(posedge clk) begin
    if (!rstN)                    balanceBit <= ODD_PARITY;
    else if (strobes.loadBalance) balanceBit <= balanceBit ^ ~parityOk;
  end
endmodule

// File: rtl/pwake_control.sv
module pwake_control
  import pwake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rearmStrobe,
  input  logic        parityOk,
  output ctrlStrobe_t strobes,
  output logic        wakeN
);
  localparam int SETTLE  = SYNC_STAGES + 1;
  localparam int CNT_W   = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] settleCnt;
  logic             settling;

  assign settling = (settleCnt < CNT_W'(SETTLE));

  always_ff @(posedge clk) begin
    if (!rstN)         settleCnt <= '0;
    else if (settling) settleCnt <= settleCnt + 1'b1;
  end

  always_comb begin
    strobes.loadBalance = settling | rearmStrobe;
    strobes.forceIdle   = settling | rearmStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  wakeN <= 1'b1;
    else if (strobes.forceIdle) wakeN <= 1'b1;
    else                        wakeN <= parityOk;
  end
endmodule

// File: rtl/parity_wake.sv
module parity_wake
  import pwake_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 rearmStrobe,
  output logic                 wakeN
);
  ctrlStrobe_t strobes;
  logic        parityOk;

  pwake_datapath #(
    .NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES), .ODD_PARITY(1'b1)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobes(strobes), .parityOk(parityOk)
  );

  pwake_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .rearmStrobe(rearmStrobe), .parityOk(parityOk),
    .strobes(strobes), .wakeN(wakeN)
  );
endmodule

// File: rtl/pwake_checker.sv
module pwake_checker #(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] lineIn,
  input logic                 rearmStrobe,
  input logic                 wakeN
);
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int HIST   = SYNC_STAGES + 2;

  logic [NUM_LINES-1:0] lineHist [HIST];
  int unsigned          sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HIST; i++) lineHist[i] <= '0;
      sinceRst <= 0;
    end else begin
      lineHist[0] <= lineIn;
      for (int i = 1; i < HIST; i++) lineHist[i] <= lineHist[i-1];
      if (sinceRst <= SETTLE) sinceRst <= sinceRst + 1;
    end
  end

  assert_settle_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst <= SETTLE) |-> wakeN);

  assert_rearm_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    rearmStrobe |=> wakeN);

  assert_fall_needs_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeN) |-> (lineHist[SYNC_STAGES] != lineHist[SYNC_STAGES+1]));

  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeN) |-> ($past(rearmStrobe) ||
                      (lineHist[SYNC_STAGES] != lineHist[SYNC_STAGES+1])));

  assert_output_known_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(wakeN));
endmodule

bind parity_wake pwake_checker #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .lineIn(lineIn), .rearmStrobe(rearmStrobe), .wakeN(wakeN)
);

// File: tb/sim_parity_wake.sv
`timescale 1ns/1ps
module sim_parity_wake;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] lineIn;
  logic       rearmStrobe;
  logic       wakeN;
  int         testsRun = 0;
  int         testsFailed = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  parity_wake u0 (.clk(clk), .rstN(rstN), .lineIn(lineIn),
                  .rearmStrobe(rearmStrobe), .wakeN(wakeN));

  task automatic check(input string req, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s wakeN actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rearm();
    rearmStrobe = 1'b1;
    waitNeg(1);
    rearmStrobe = 1'b0;
  endtask

  // R1, R2: reset and settle with nonzero lines
  task automatic testReset();
    rstN = 1'b0; rearmStrobe = 1'b0; lineIn = 8'hA7;
    waitNeg(3);
    check("R1 in reset", wakeN, 1'b1);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      waitNeg(1);
      check("R1 settle", wakeN, 1'b1);
    end
    for (int i = 0; i < 5; i++) begin
      waitNeg(1);
      check("R2 idle", wakeN, 1'b1);
    end
  endtask

  // R3, R5, R4: single line change then re-arm
  task automatic testSingle(input int bitIdx);
    lineIn[bitIdx] = ~lineIn[bitIdx];
    waitNeg(2);
    check("R3 not early", wakeN, 1'b1);
    waitNeg(1);
    check("R5 line change seen", wakeN, 1'b0);
    waitNeg(2);
    check("R3 held low", wakeN, 1'b0);
    rearm();
    check("R4 rearm high", wakeN, 1'b1);
    waitNeg(3);
    check("R4 stays high", wakeN, 1'b1);
  endtask

  // R6: two-line simultaneous change is invisible
  task automatic testDouble();
    lineIn = lineIn ^ 8'b0001_0010;
    for (int i = 0; i < 6; i++) begin
      waitNeg(1);
      check("R6 blind spot", wakeN, 1'b1);
    end
  endtask

  // R7: revert without re-arm
  task automatic testRevert();
    lineIn[6] = ~lineIn[6];
    waitNeg(3);
    check("R7 low after change", wakeN, 1'b0);
    lineIn[6] = ~lineIn[6];
    waitNeg(2);
    check("R7 still low", wakeN, 1'b0);
    waitNeg(1);
    check("R7 back high", wakeN, 1'b1);
  endtask

  // R8: one-edge pulse gives one low cycle
  task automatic testPulse();
    lineIn[2] = ~lineIn[2];
    waitNeg(1);
    lineIn[2] = ~lineIn[2];
    waitNeg(2);
    check("R8 pulse low", wakeN, 1'b0);
    waitNeg(1);
    check("R8 pulse one cycle", wakeN, 1'b1);
  endtask

  // R9: odd parity balance after re-arm across several line patterns
  task automatic testPatterns();
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h3C, 8'h81};
    for (int p = 0; p < 4; p++) begin
      lineIn = pats[p];
      waitNeg(4);
      rearm();
      waitNeg(2);
      check("R9 balanced", wakeN, 1'b1);
      lineIn[p] = ~lineIn[p];
      waitNeg(3);
      check("R9 odd count broken", wakeN, 1'b0);
      rearm();
    end
  endtask

  initial begin
    testReset();
    for (int b = 0; b < 8; b++) testSingle(b);
    testDouble();
    testRevert();
    testPulse();
    testPatterns();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule